// File: doc/BRIEF.md
# Two-Bank Multiplexed Port Status and Meter LED Driver

This block drives a row of LED pins together with a single bank-select line, so that each pin lights one of two LEDs depending on the bank level. The pins are split into two groups. The low group shows an eight-segment power meter, and the high group shows eight per-port status lamps. The bank line alternates every millisecond, and the pins carry the half of each set that belongs to the current bank level.

Each port supplies a 3-bit status code. The block turns the code into a blink cadence inside a shared 2000 ms frame. The cadences are a short single flash, steady on, steady on with one short dark gap, a fast repeating flash, and a double flash. A prescaler derives a millisecond tick from the system clock, with the divide ratio set by the clock frequency parameter. All ports use one frame counter, so every lamp with the same code blinks in step with the others. The meter pattern is passed through as given.

Top module: `ledmux_top`

## Requirements
- R1: With D = CLK_HZ/TICK_HZ, millisecond m after reset release spans clocks m*D+1 to m*D+D, counting the first edge with reset low as clock 1. During millisecond m, bank_pin is 1 when m is odd and 0 when m is even, so it is high for 1 ms and low for 1 ms.
- R2: Pins led_pin[3:0] show meter_bits[3:0] while bank_pin is 1, and meter_bits[7:4] while bank_pin is 0.
- R3: Pins led_pin[7:4] show the lamps of ports 0..3 while bank_pin is 1, and of ports 4..7 while bank_pin is 0. Port p's code sits in port_status[3p+2:3p].
- R4: Code 1 (detecting) lights the lamp only during frame milliseconds 0..99 of the 2000 ms frame.
- R5: Code 2 (powered) keeps the lamp lit for the whole frame.
- R6: Code 3 (high-power grant) keeps the lamp dark during frame milliseconds 0..99 and lit for the rest of the frame.
- R7: Code 4 (overload) lights the lamp when the frame millisecond modulo 200 is below 100, which gives five flashes per second.
- R8: Code 5 (denied) lights the lamp during frame milliseconds 0..99 and 200..299 only.
- R9: Codes 0, 6 and 7 keep the lamp dark.
- R10: While rst is high on a clock edge, led_pin and bank_pin go to 0 on that edge. After release, the frame and the bank phase restart from millisecond 0.
- R11: Ports that hold the same code show the same lamp level in the same millisecond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_status | input | 24 | Eight 3-bit port codes; port p at bits 3p+2:3p |
| meter_bits | input | 8 | Power meter segment pattern |
| led_pin | output | 8 | LED pin levels: [3:0] meter, [7:4] port lamps |
| bank_pin | output | 1 | Bank select, 1 ms high / 1 ms low |

## Verification
Each status code is held on all eight ports at once and sampled at chosen frame milliseconds. The samples sit on both sides of every cadence edge (99/100, 150/250, 299/350) and near the end of the frame, which separates cadences that look alike, such as the single flash against the double flash and the dark-gap pattern against steady on. Because both odd and even milliseconds are sampled, each code is seen through both bank levels, and the fixed meter pattern reveals any swap of the nibbles. A mixed assignment with a different code on each port shows whether the lamps are routed to the right pins. A reset in the middle of a frame shows whether the frame phase restarts from millisecond 0.

// File: rtl/ledmux_pkg.sv
package ledmux_pkg;

    localparam int FRAME_MS       = 2000;
    localparam int FLASH_MS       = 100;
    localparam int PAIR_GAP_MS    = 200;
    localparam int FAST_PERIOD_MS = 200;
    localparam int MS_W           = $clog2(FRAME_MS);
    localparam int FAST_W         = $clog2(FAST_PERIOD_MS);
    localparam int CODE_W         = 3;

    typedef logic [MS_W-1:0]   ms_t;
    typedef logic [FAST_W-1:0] fast_t;

    typedef enum logic [CODE_W-1:0] {
        ST_IDLE     = 3'd0,
        ST_DETECT   = 3'd1,
        ST_POWERED  = 3'd2,
        ST_HIGHPWR  = 3'd3,
        ST_OVERLOAD = 3'd4,
        ST_DENIED   = 3'd5,
        ST_RSVD6    = 3'd6,
        ST_RSVD7    = 3'd7
    } port_state_e;

    typedef struct packed {
        logic  bank;
        ms_t   ms;
        fast_t fast;
    } timebase_t;

    function automatic logic cadence_lit(port_state_e st, timebase_t tb);
        logic first_flash;
        logic second_flash;
        logic fast_flash;
        first_flash  = (tb.ms < ms_t'(FLASH_MS));
        second_flash = (tb.ms >= ms_t'(PAIR_GAP_MS)) &&
                       (tb.ms <  ms_t'(PAIR_GAP_MS + FLASH_MS));
        fast_flash   = (tb.fast < fast_t'(FLASH_MS));
        case (st)
            ST_DETECT:   return first_flash;
            ST_POWERED:  return 1'b1;
            ST_HIGHPWR:  return !first_flash;
            ST_OVERLOAD: return fast_flash;
            ST_DENIED:   return first_flash || second_flash;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ledmux_tick.sv
module ledmux_tick #(
    parameter int DIV = 50_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ledmux_frame.sv
module ledmux_frame
    import ledmux_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    output timebase_t tb
);
    timebase_t tb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_q <= '0;
        end else if (tick) begin
            tb_q.bank <= !tb_q.bank;
            tb_q.ms   <= (tb_q.ms == ms_t'(FRAME_MS - 1)) ? '0 : tb_q.ms + 1'b1;
            tb_q.fast <= (tb_q.fast == fast_t'(FAST_PERIOD_MS - 1)) ? '0 : tb_q.fast + 1'b1;
        end
    end

    assign tb = tb_q;
endmodule

// File: rtl/ledmux_pattern.sv
module ledmux_pattern
    import ledmux_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  timebase_t                     tb,
    input  logic [NUM_PORTS*CODE_W-1:0]   port_status,
    output logic [NUM_PORTS-1:0]          lit
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign lit[p] = cadence_lit(port_state_e'(port_status[p*CODE_W +: CODE_W]), tb);
    end
endmodule

// File: rtl/ledmux_drive.sv
module ledmux_drive #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bank,
    input  logic [NUM_PORTS-1:0] lit,
    input  logic [NUM_PORTS-1:0] meter_bits,
    output logic [NUM_PORTS-1:0] led_pin,
    output logic                 bank_pin
);
    localparam int HALF = NUM_PORTS / 2;

    logic [NUM_PORTS-1:0] pins_d;

    always_comb begin
        if (bank) begin
            pins_d = {lit[HALF-1:0], meter_bits[HALF-1:0]};
        end else begin
            pins_d = {lit[NUM_PORTS-1:HALF], meter_bits[NUM_PORTS-1:HALF]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led_pin  <= '0;
            bank_pin <= 1'b0;
        end else begin
            led_pin  <= pins_d;
            bank_pin <= bank;
        end
    end
endmodule

// File: rtl/ledmux_top.sv
module ledmux_top
    import ledmux_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int TICK_HZ   = 1000,
    parameter int NUM_PORTS = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORTS*CODE_W-1:0]    port_status,
    input  logic [NUM_PORTS-1:0]           meter_bits,
    output logic [NUM_PORTS-1:0]           led_pin,
    output logic                           bank_pin
);
    localparam int TICK_DIV = CLK_HZ / TICK_HZ;

    logic                 w_tick;
    timebase_t            w_tb;
    logic                 w_bank;
    ms_t                  w_ms;
    logic [NUM_PORTS-1:0] w_lit;

    assign w_bank = w_tb.bank;
    assign w_ms   = w_tb.ms;

    ledmux_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (w_tick)
    );

    ledmux_frame u_frame (
        .clk  (clk),
        .rst  (rst),
        .tick (w_tick),
        .tb   (w_tb)
    );

    ledmux_pattern #(.NUM_PORTS(NUM_PORTS)) u_pattern (
        .tb          (w_tb),
        .port_status (port_status),
        .lit         (w_lit)
    );

    ledmux_drive #(.NUM_PORTS(NUM_PORTS)) u_drive (
        .clk        (clk),
        .rst        (rst),
        .bank       (w_bank),
        .lit        (w_lit),
        .meter_bits (meter_bits),
        .led_pin    (led_pin),
        .bank_pin   (bank_pin)
    );
endmodule

// File: rtl/ledmux_chk.sv
module ledmux_chk
    import ledmux_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         tick,
    input logic                         bank_q,
    input ms_t                          ms_q,
    input logic [NUM_PORTS*CODE_W-1:0]  port_status,
    input logic [NUM_PORTS-1:0]         led_pin,
    input logic                         bank_pin
);
    localparam int HALF = NUM_PORTS / 2;

    logic all_powered;
    logic all_idle;

    always_comb begin
        all_powered = 1'b1;
        all_idle    = 1'b1;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_status[p*CODE_W +: CODE_W] != CODE_W'(ST_POWERED)) all_powered = 1'b0;
            if (port_status[p*CODE_W +: CODE_W] != CODE_W'(ST_IDLE))    all_idle    = 1'b0;
        end
    end

    assert_bank_flips_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (bank_q != $past(bank_q)));

    assert_bank_holds_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(bank_q));

    assert_frame_bound_R4: assert property (@(posedge clk) disable iff (rst)
        ms_q < ms_t'(FRAME_MS));

    assert_pin_follows_bank_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (bank_pin == $past(bank_q)));

    assert_steady_on_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(all_powered)) |-> (led_pin[NUM_PORTS-1:HALF] == '1));

    assert_dark_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(all_idle)) |-> (led_pin[NUM_PORTS-1:HALF] == '0));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (led_pin == '0 && !bank_pin));
endmodule

bind ledmux_top ledmux_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (w_tick),
    .bank_q      (w_bank),
    .ms_q        (w_ms),
    .port_status (port_status),
    .led_pin     (led_pin),
    .bank_pin    (bank_pin)
);

// File: tb/ledmux_top_bench.sv
module ledmux_top_bench;
    localparam int CLK_HZ  = 2000;
    localparam int TICK_HZ = 1000;
    localparam int DIV     = CLK_HZ / TICK_HZ;
    localparam int NP      = 8;
    localparam int FRAME   = 2000;
    localparam int FCYC    = FRAME * DIV;
    localparam int NVEC    = 22;

    // code, frame millisecond, expected lamp level
    localparam int VEC [NVEC][3] = '{
        '{1, 1, 1}, '{1, 99, 1}, '{1, 100, 0}, '{1, 1500, 0},
        '{2, 3, 1}, '{2, 1998, 1},
        '{3, 51, 0}, '{3, 100, 1}, '{3, 1999, 1},
        '{4, 50, 1}, '{4, 150, 0}, '{4, 250, 1}, '{4, 1901, 0},
        '{5, 10, 1}, '{5, 150, 0}, '{5, 250, 1}, '{5, 299, 1}, '{5, 350, 0}, '{5, 1250, 0},
        '{0, 500, 0}, '{6, 40, 0}, '{7, 41, 0}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP*3-1:0] port_status = '0;
    logic [NP-1:0]   meter_bits = 8'hA5;
    logic [NP-1:0]   led_pin;
    logic            bank_pin;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    ledmux_top #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .NUM_PORTS(NP)) u_ledmux_top (
        .clk         (clk),
        .rst         (rst),
        .port_status (port_status),
        .meter_bits  (meter_bits),
        .led_pin     (led_pin),
        .bank_pin    (bank_pin)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    task automatic set_all(input int code);
        for (int p = 0; p < NP; p++) port_status[p*3 +: 3] = 3'(code);
    endtask

    task automatic wait_ms(input int m);
        do @(negedge clk); while ((cyc % FCYC) != ((m * DIV + 1) % FCYC));
    endtask

    function automatic string req_of(input int code);
        case (code)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        // reset state R10
        repeat (3) @(negedge clk);
        chk("R10 pins in reset", led_pin, 8'h00);
        chk("R10 bank in reset", {7'b0, bank_pin}, 8'h00);
        rst = 1'b0;

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            int m;
            logic bexp;
            m = VEC[i][1];
            set_all(VEC[i][0]);
            wait_ms(m);
            bexp = (m % 2) == 1;
            chk("R1 bank level", {7'b0, bank_pin}, {7'b0, bexp});
            chk("R2 meter nibble", {4'h0, led_pin[3:0]}, {4'h0, bexp ? meter_bits[3:0] : meter_bits[7:4]});
            chk({req_of(VEC[i][0]), " R11 lamps"}, {4'h0, led_pin[7:4]}, {4'h0, {4{VEC[i][2] != 0}}});
        end

        // mixed per-port codes, R3 routing
        port_status = {3'd4, 3'd5, 3'd2, 3'd0, 3'd1, 3'd3, 3'd0, 3'd2};
        meter_bits  = 8'h3C;
        wait_ms(1);
        chk("R3 ports 0..3 at ms1", {4'h0, led_pin[7:4]}, 8'h09);
        chk("R2 meter low nibble", {4'h0, led_pin[3:0]}, 8'h0C);
        wait_ms(2);
        chk("R3 ports 4..7 at ms2", {4'h0, led_pin[7:4]}, 8'h0E);
        chk("R2 meter high nibble", {4'h0, led_pin[3:0]}, 8'h03);
        wait_ms(151);
        chk("R3 ports 0..3 at ms151", {4'h0, led_pin[7:4]}, 8'h05);

        // mid-frame reset, R10 restart
        set_all(1);
        wait_ms(700);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 pins after mid reset", led_pin, 8'h00);
        chk("R10 bank after mid reset", {7'b0, bank_pin}, 8'h00);
        rst = 1'b0;
        wait_ms(0);
        chk("R10 restart ms0 lamps", {4'h0, led_pin[7:4]}, 8'h0F);
        chk("R10 restart ms0 bank", {7'b0, bank_pin}, 8'h00);
        wait_ms(1);
        chk("R1 first high bank", {7'b0, bank_pin}, 8'h01);
        wait_ms(100);
        chk("R4 restart dark at ms100", {4'h0, led_pin[7:4]}, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule